// File: doc/BRIEF.md
# Secret-Code Access Controller for a Memory Card

This block decides what a memory card may read, write or lock. It holds a 1024-byte data store and a matching store of one-time lock bits, one per data byte. Three bytes at the top of the data store are special: the lowest of them counts the remaining verification attempts, and the two above it hold the secret code. Before the code is proven, the code bytes read as zero and the attempt counter is the only byte that may change. Once both code bytes have been matched in the proper order, the whole store opens for reading and editing until the next power-on reset.

Each verification attempt spends one set bit of the attempt counter before any comparison is made. A full match refills the counter with all ones. A miss leaves the spent bit cleared, so after eight misses the counter is zero and the card is locked for good: no byte, including the counter itself, can change again. A lock bit, once set, cannot be cleared and refuses every later edit of its byte.

Commands arrive one per clock as an opcode, an address and a data byte. Each one produces a registered response on the next clock: read data, the lock bit of the addressed byte, and exactly one of granted or refused.

Top module: `secret_access_ctrl`

## Requirements
- R1: After power-on the data store reads all ones and every lock bit reads zero; while `rst` is high and in the first cycle after, `rsp_valid`, `rsp_granted`, `rsp_refused` and `unlocked` are low.
- R2: A command accepted at a clock edge (`cmd_valid` high) gives `rsp_valid` high one cycle later with exactly one of `rsp_granted`/`rsp_refused`; a read (opcode 0) is always granted and returns the byte at `cmd_addr`, except that while locked-out of the code (`unlocked` low) addresses 1022 and 1023 return 0x00.
- R3: A read also returns the lock bit of the addressed byte on `rsp_prot`.
- R4: While `unlocked` is low, plain write (opcode 1), write-and-lock (opcode 2) and lock-if-equal (opcode 3) are refused and change no byte or lock bit.
- R5: The strike command (opcode 4, address ignored) ANDs `cmd_data` into the counter byte at address 1021; it is granted only if the result has exactly one set bit fewer than before, otherwise it is refused and the counter is unchanged.
- R6: Verification is strike, then first-code compare (opcode 5, data checked against byte 1022), then second-code compare (opcode 6, data checked against byte 1023), each accepted only right after its predecessor; any other command in between restarts the sequence and an out-of-order compare is refused. When both compares match, `unlocked` rises and the counter becomes 0xFF.
- R7: A failed attempt leaves `unlocked` low and the struck counter bit cleared.
- R8: While `unlocked` is high, any address 0 to 1023 can be written, and bytes 1022/1023 read their true values.
- R9: Write-and-lock stores the byte and sets its lock bit; a byte whose lock bit is set refuses every later write or lock command and keeps its value and lock bit.
- R10: Lock-if-equal sets the lock bit only when `cmd_data` equals the stored byte, without changing the byte; otherwise it is refused.
- R11: When the counter byte is zero, `locked` is high and every command other than read, strike included, is refused.
- R12: `rst` clears `unlocked` and restarts the sequence but keeps all stored bytes and lock bits.
- R13: Opcode 7 is refused and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (0 read, 1 write, 2 write-and-lock, 3 lock-if-equal, 4 strike, 5 first code, 6 second code) |
| cmd_addr | input | 10 | Byte address |
| cmd_data | input | 8 | Data, strike mask or code byte |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 8 | Read data, masked for code bytes while closed |
| rsp_prot | output | 1 | Lock bit of the addressed byte |
| rsp_granted | output | 1 | Command was carried out |
| rsp_refused | output | 1 | Command was refused |
| unlocked | output | 1 | Secret code has been proven since reset |
| locked | output | 1 | Attempt counter is exhausted |

## Verification
The attempt sequence is tried with a strike that clears no bit, one that clears two bits, a compare issued out of order, a wrong second code, a full match, and eight wrong attempts in a row; these separate the one-bit spending rule, the ordering rule, the refill on success and the permanent lockout. Edits are tried before and after proving the code, on locked and unlocked bytes, and lock-if-equal with a matching and a differing byte, which distinguishes the code gate from the lock-bit gate. A reset after opening shows the flag closing while the stored bytes survive.

// File: rtl/sca_pkg.sv
package sca_pkg;

    localparam int unsigned CARD_AW = 10;
    localparam int unsigned CARD_DW = 8;

    typedef enum logic [2:0] {
        OP_READ       = 3'd0,
        OP_WRITE      = 3'd1,
        OP_WRITE_LOCK = 3'd2,
        OP_LOCK_IF_EQ = 3'd3,
        OP_STRIKE     = 3'd4,
        OP_CODE_A     = 3'd5,
        OP_CODE_B     = 3'd6,
        OP_RSVD       = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        VS_IDLE  = 2'd0,
        VS_ARMED = 2'd1,
        VS_HALF  = 2'd2
    } vstate_e;

    typedef struct packed {
        logic grant;
        logic mem_wr;
        logic set_prot;
    } verdict_t;

    // True for the opcodes that edit an ordinary byte.
    function automatic logic is_edit_op(input op_e op);
        return (op == OP_WRITE) || (op == OP_WRITE_LOCK) || (op == OP_LOCK_IF_EQ);
    endfunction

endpackage

// File: rtl/sca_store.sv
module sca_store #(
    parameter int unsigned AW = sca_pkg::CARD_AW,
    parameter int unsigned DW = sca_pkg::CARD_DW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          set_prot,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_byte,
    output logic          rd_prot,
    output logic [DW-1:0] ctr_byte,
    output logic [DW-1:0] code_a_byte,
    output logic [DW-1:0] code_b_byte
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [AW-1:0] CTR_ADDR  = AW'(DEPTH - 3);
    localparam logic [AW-1:0] CODEA_ADDR = AW'(DEPTH - 2);
    localparam logic [AW-1:0] CODEB_ADDR = AW'(DEPTH - 1);

    logic [DW-1:0] cells [DEPTH];
    logic          locks [DEPTH];

    // Fresh die: cells erased to ones, no lock bit programmed.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            cells[i] = '1;
            locks[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
        if (set_prot) begin
            locks[wr_addr] <= 1'b1;
        end
    end

    assign rd_byte     = cells[rd_addr];
    assign rd_prot     = locks[rd_addr];
    assign ctr_byte    = cells[CTR_ADDR];
    assign code_a_byte = cells[CODEA_ADDR];
    assign code_b_byte = cells[CODEB_ADDR];

endmodule

// File: rtl/sca_policy.sv
module sca_policy
    import sca_pkg::*;
#(
    parameter int unsigned AW = sca_pkg::CARD_AW,
    parameter int unsigned DW = sca_pkg::CARD_DW
) (
    input  op_e           op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] cur_byte,
    input  logic          cur_prot,
    input  logic [DW-1:0] ctr_byte,
    input  logic          unlocked,
    input  logic          locked,
    input  vstate_e       vstate,
    output verdict_t      verdict,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [AW-1:0] CTR_ADDR = AW'(DEPTH - 3);

    logic          may_edit;
    logic          eq_ok;
    logic          strike_ok;
    logic [DW-1:0] struck;

    always_comb begin
        may_edit  = unlocked && !locked && !cur_prot;
        eq_ok     = may_edit && (data == cur_byte);
        struck    = ctr_byte & data;
        strike_ok = !locked && ($countones(ctr_byte) == $countones(struck) + 1);
        verdict   = '0;
        wr_addr   = addr;
        wr_data   = data;
        case (op)
            OP_READ: begin
                verdict.grant = 1'b1;
            end
            OP_WRITE: begin
                verdict.grant  = may_edit;
                verdict.mem_wr = may_edit;
            end
            OP_WRITE_LOCK: begin
                verdict.grant    = may_edit;
                verdict.mem_wr   = may_edit;
                verdict.set_prot = may_edit;
            end
            OP_LOCK_IF_EQ: begin
                verdict.grant    = eq_ok;
                verdict.set_prot = eq_ok;
            end
            OP_STRIKE: begin
                verdict.grant  = strike_ok;
                verdict.mem_wr = strike_ok;
                wr_addr        = CTR_ADDR;
                wr_data        = struck;
            end
            OP_CODE_A: begin
                verdict.grant = !locked && (vstate == VS_ARMED);
            end
            OP_CODE_B: begin
                verdict.grant = !locked && (vstate == VS_HALF);
            end
            default: begin
                verdict = '0;
            end
        endcase
    end

endmodule

// File: rtl/sca_verify.sv
module sca_verify
    import sca_pkg::*;
#(
    parameter int unsigned DW = sca_pkg::CARD_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  op_e           op,
    input  logic          grant,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] code_a_byte,
    input  logic [DW-1:0] code_b_byte,
    output vstate_e       vstate,
    output logic          unlocked,
    output logic          refill
);
    vstate_e state_q;
    logic    first_ok_q;
    logic    unlocked_q;

    assign refill = cmd_valid && grant && (op == OP_CODE_B) && first_ok_q &&
                    (data == code_b_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= VS_IDLE;
            first_ok_q <= 1'b0;
            unlocked_q <= 1'b0;
        end else if (cmd_valid) begin
            state_q <= VS_IDLE;
            if (grant) begin
                case (op)
                    OP_STRIKE: begin
                        state_q <= VS_ARMED;
                    end
                    OP_CODE_A: begin
                        state_q    <= VS_HALF;
                        first_ok_q <= (data == code_a_byte);
                    end
                    OP_CODE_B: begin
                        first_ok_q <= 1'b0;
                        if (refill) begin
                            unlocked_q <= 1'b1;
                        end
                    end
                    default: begin
                        state_q <= VS_IDLE;
                    end
                endcase
            end
        end
    end

    assign vstate   = state_q;
    assign unlocked = unlocked_q;

endmodule

// File: rtl/secret_access_ctrl.sv
module secret_access_ctrl
    import sca_pkg::*;
#(
    parameter int unsigned AW = sca_pkg::CARD_AW,
    parameter int unsigned DW = sca_pkg::CARD_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_prot,
    output logic          rsp_granted,
    output logic          rsp_refused,
    output logic          unlocked,
    output logic          locked
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [AW-1:0] CTR_ADDR   = AW'(DEPTH - 3);
    localparam logic [AW-1:0] CODEA_ADDR = AW'(DEPTH - 2);

    op_e           op;
    verdict_t      verdict;
    vstate_e       vstate;
    logic [AW-1:0] pol_addr;
    logic [DW-1:0] pol_data;
    logic [DW-1:0] rd_byte;
    logic          rd_prot;
    logic [DW-1:0] ctr_byte;
    logic [DW-1:0] code_a_byte;
    logic [DW-1:0] code_b_byte;
    logic          refill;
    logic          unlocked_w;
    logic          st_wr;
    logic          st_prot;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic [DW-1:0] shown_byte;

    assign op     = op_e'(cmd_op);
    assign locked = (ctr_byte == '0);

    sca_store #(.AW(AW), .DW(DW)) u_store (
        .clk        (clk),
        .wr_en      (st_wr),
        .set_prot   (st_prot),
        .wr_addr    (st_addr),
        .wr_data    (st_data),
        .rd_addr    (cmd_addr),
        .rd_byte    (rd_byte),
        .rd_prot    (rd_prot),
        .ctr_byte   (ctr_byte),
        .code_a_byte(code_a_byte),
        .code_b_byte(code_b_byte)
    );

    sca_policy #(.AW(AW), .DW(DW)) u_policy (
        .op      (op),
        .addr    (cmd_addr),
        .data    (cmd_data),
        .cur_byte(rd_byte),
        .cur_prot(rd_prot),
        .ctr_byte(ctr_byte),
        .unlocked(unlocked_w),
        .locked  (locked),
        .vstate  (vstate),
        .verdict (verdict),
        .wr_addr (pol_addr),
        .wr_data (pol_data)
    );

    sca_verify #(.DW(DW)) u_verify (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .op         (op),
        .grant      (verdict.grant),
        .data       (cmd_data),
        .code_a_byte(code_a_byte),
        .code_b_byte(code_b_byte),
        .vstate     (vstate),
        .unlocked   (unlocked_w),
        .refill     (refill)
    );

    // A successful second compare refills the counter; otherwise the policy drives the store.
    always_comb begin
        st_wr   = cmd_valid && verdict.mem_wr;
        st_prot = cmd_valid && verdict.set_prot;
        st_addr = pol_addr;
        st_data = pol_data;
        if (refill) begin
            st_wr   = 1'b1;
            st_prot = 1'b0;
            st_addr = CTR_ADDR;
            st_data = '1;
        end
    end

    assign shown_byte = (!unlocked_w && (cmd_addr >= CODEA_ADDR)) ? '0 : rd_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
            rsp_prot    <= 1'b0;
            rsp_granted <= 1'b0;
            rsp_refused <= 1'b0;
        end else begin
            rsp_valid   <= cmd_valid;
            rsp_data    <= shown_byte;
            rsp_prot    <= rd_prot;
            rsp_granted <= cmd_valid && verdict.grant;
            rsp_refused <= cmd_valid && !verdict.grant;
        end
    end

    assign unlocked = unlocked_w;

endmodule

// File: rtl/sca_checker.sv
module sca_checker
    import sca_pkg::*;
#(
    parameter int unsigned AW = sca_pkg::CARD_AW,
    parameter int unsigned DW = sca_pkg::CARD_DW
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [AW-1:0] cmd_addr,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          rsp_granted,
    input logic          rsp_refused,
    input logic          unlocked,
    input logic          locked
);
    localparam logic [AW-1:0] CODEA_ADDR = AW'((1 << AW) - 2);

    p_rsp_timing_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    p_one_verdict_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_granted != rsp_refused));

    p_code_hidden_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_READ && !unlocked && cmd_addr >= CODEA_ADDR)
        |=> (rsp_data == '0));

    p_closed_edit_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_edit_op(op_e'(cmd_op)) && !unlocked) |=> rsp_refused);

    p_unlock_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(cmd_valid && cmd_op == OP_CODE_B));

    p_lockout_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && locked && cmd_op != OP_READ) |=> rsp_refused);

    p_bad_op_r13: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RSVD) |=> rsp_refused);

endmodule

bind secret_access_ctrl sca_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_granted(rsp_granted),
    .rsp_refused(rsp_refused),
    .unlocked   (unlocked),
    .locked     (locked)
);

// File: tb/secret_access_ctrl_tb.sv
module secret_access_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [9:0] cmd_addr = 10'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       rsp_prot;
    logic       rsp_granted;
    logic       rsp_refused;
    logic       unlocked;
    logic       locked;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] r_data;
    logic       r_prot;
    logic       r_grant;
    logic       r_refuse;
    logic [7:0] exp_ctr;

    always #2 clk = ~clk;

    secret_access_ctrl u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_prot(rsp_prot), .rsp_granted(rsp_granted),
        .rsp_refused(rsp_refused), .unlocked(unlocked), .locked(locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample the registered response at the next falling edge.
    task automatic issue(input logic [2:0] op, input logic [9:0] addr, input logic [7:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_data  = data;
        @(negedge clk);
        r_data    = rsp_data;
        r_prot    = rsp_prot;
        r_grant   = rsp_granted;
        r_refuse  = rsp_refused;
        chk("R2 rsp_valid", int'(rsp_valid), 1);
        chk("R2 one verdict", int'(r_grant ^ r_refuse), 1);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] low_bit(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            if (v[i]) return 8'(1 << i);
        end
        return 8'h00;
    endfunction

    task automatic t_reset_state();
        @(negedge clk);
        chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
        chk("R1 unlocked in reset", int'(unlocked), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 granted after reset", int'(rsp_granted), 0);
        chk("R1 refused after reset", int'(rsp_refused), 0);
        chk("R1 locked low", int'(locked), 0);
        issue(3'd0, 10'd5, 8'h00);
        chk("R1 erased byte", int'(r_data), 8'hFF);
        chk("R3 fresh lock bit", int'(r_prot), 0);
    endtask

    task automatic t_closed_reads();
        issue(3'd0, 10'd1021, 8'h00);
        chk("R2 counter readable", int'(r_data), 8'hFF);
        issue(3'd0, 10'd1022, 8'h00);
        chk("R2 code A hidden", int'(r_data), 8'h00);
        issue(3'd0, 10'd1023, 8'h00);
        chk("R2 code B hidden", int'(r_data), 8'h00);
    endtask

    task automatic t_closed_edits();
        issue(3'd1, 10'd5, 8'h12);
        chk("R4 write refused", int'(r_refuse), 1);
        issue(3'd2, 10'd6, 8'h34);
        chk("R4 write-lock refused", int'(r_refuse), 1);
        issue(3'd3, 10'd7, 8'hFF);
        chk("R4 lock-if-equal refused", int'(r_refuse), 1);
        issue(3'd0, 10'd5, 8'h00);
        chk("R4 byte kept", int'(r_data), 8'hFF);
        issue(3'd0, 10'd6, 8'h00);
        chk("R4 byte kept 6", int'(r_data), 8'hFF);
        chk("R4 lock bit kept", int'(r_prot), 0);
    endtask

    task automatic t_strike_rules();
        issue(3'd4, 10'd0, 8'hFF);
        chk("R5 no-bit strike refused", int'(r_refuse), 1);
        issue(3'd4, 10'd0, 8'hFC);
        chk("R5 two-bit strike refused", int'(r_refuse), 1);
        issue(3'd0, 10'd1021, 8'h00);
        chk("R5 counter unchanged", int'(r_data), 8'hFF);
        issue(3'd5, 10'd0, 8'hFF);
        chk("R6 compare out of order", int'(r_refuse), 1);
    endtask

    task automatic t_failed_try();
        issue(3'd4, 10'd0, 8'hFE);
        chk("R5 one-bit strike", int'(r_grant), 1);
        issue(3'd5, 10'd0, 8'hFF);
        chk("R6 first compare accepted", int'(r_grant), 1);
        issue(3'd6, 10'd0, 8'h00);
        chk("R6 second compare accepted", int'(r_grant), 1);
        chk("R7 still closed", int'(unlocked), 0);
        issue(3'd0, 10'd1021, 8'h00);
        chk("R7 bit stays cleared", int'(r_data), 8'hFE);
        // Sequence broken by a read between strike and compare.
        issue(3'd4, 10'd0, 8'hFD);
        issue(3'd0, 10'd0, 8'h00);
        issue(3'd5, 10'd0, 8'hFF);
        chk("R6 interrupted sequence", int'(r_refuse), 1);
    endtask

    task automatic t_good_try();
        issue(3'd4, 10'd0, 8'hFB);
        chk("R6 strike", int'(r_grant), 1);
        issue(3'd5, 10'd0, 8'hFF);
        issue(3'd6, 10'd0, 8'hFF);
        chk("R6 unlocked", int'(unlocked), 1);
        issue(3'd0, 10'd1021, 8'h00);
        chk("R6 counter refilled", int'(r_data), 8'hFF);
    endtask

    task automatic t_open_edits();
        issue(3'd1, 10'd1022, 8'h5A);
        chk("R8 write code A", int'(r_grant), 1);
        issue(3'd1, 10'd1023, 8'hC3);
        issue(3'd0, 10'd1022, 8'h00);
        chk("R8 code A visible", int'(r_data), 8'h5A);
        issue(3'd0, 10'd1023, 8'h00);
        chk("R8 code B visible", int'(r_data), 8'hC3);
        issue(3'd1, 10'd10, 8'h33);
        issue(3'd0, 10'd10, 8'h00);
        chk("R8 ordinary write", int'(r_data), 8'h33);
    endtask

    task automatic t_protect();
        issue(3'd2, 10'd20, 8'h77);
        chk("R9 write-lock granted", int'(r_grant), 1);
        issue(3'd0, 10'd20, 8'h00);
        chk("R9 data stored", int'(r_data), 8'h77);
        chk("R3 lock bit set", int'(r_prot), 1);
        issue(3'd1, 10'd20, 8'h00);
        chk("R9 locked byte refuses", int'(r_refuse), 1);
        issue(3'd2, 10'd20, 8'h11);
        chk("R9 locked byte refuses lock", int'(r_refuse), 1);
        issue(3'd0, 10'd20, 8'h00);
        chk("R9 value kept", int'(r_data), 8'h77);
        chk("R9 lock kept", int'(r_prot), 1);
    endtask

    task automatic t_protect_cmp();
        issue(3'd3, 10'd10, 8'h34);
        chk("R10 mismatch refused", int'(r_refuse), 1);
        issue(3'd0, 10'd10, 8'h00);
        chk("R10 no lock on mismatch", int'(r_prot), 0);
        issue(3'd3, 10'd10, 8'h33);
        chk("R10 match granted", int'(r_grant), 1);
        issue(3'd0, 10'd10, 8'h00);
        chk("R10 lock set", int'(r_prot), 1);
        chk("R10 byte unchanged", int'(r_data), 8'h33);
    endtask

    task automatic t_bad_op();
        issue(3'd7, 10'd30, 8'h00);
        chk("R13 reserved refused", int'(r_refuse), 1);
        issue(3'd0, 10'd30, 8'h00);
        chk("R13 byte untouched", int'(r_data), 8'hFF);
        chk("R13 lock untouched", int'(r_prot), 0);
    endtask

    task automatic t_reset_relock();
        pulse_reset();
        chk("R12 unlocked cleared", int'(unlocked), 0);
        issue(3'd0, 10'd1022, 8'h00);
        chk("R12 code hidden again", int'(r_data), 8'h00);
        issue(3'd0, 10'd10, 8'h00);
        chk("R12 data kept", int'(r_data), 8'h33);
        chk("R12 lock kept", int'(r_prot), 1);
        issue(3'd4, 10'd0, 8'hFE);
        issue(3'd5, 10'd0, 8'h5A);
        issue(3'd6, 10'd0, 8'hC3);
        chk("R6 new code opens", int'(unlocked), 1);
    endtask

    task automatic t_lockout();
        pulse_reset();
        exp_ctr = 8'hFF;
        for (int k = 0; k < 8; k++) begin
            issue(3'd4, 10'd0, ~low_bit(exp_ctr));
            exp_ctr = exp_ctr & ~low_bit(exp_ctr);
            issue(3'd5, 10'd0, 8'h00);
            issue(3'd6, 10'd0, 8'h00);
        end
        chk("R7 still closed after misses", int'(unlocked), 0);
        issue(3'd0, 10'd1021, 8'h00);
        chk("R11 counter exhausted", int'(r_data), int'(exp_ctr));
        chk("R11 locked flag", int'(locked), 1);
        issue(3'd4, 10'd0, 8'hFF);
        chk("R11 strike refused", int'(r_refuse), 1);
        issue(3'd5, 10'd0, 8'h5A);
        chk("R11 compare refused", int'(r_refuse), 1);
    endtask

    initial begin
        t_reset_state();
        t_closed_reads();
        t_closed_edits();
        t_strike_rules();
        t_failed_try();
        t_good_try();
        t_open_edits();
        t_protect();
        t_protect_cmp();
        t_bad_op();
        t_reset_relock();
        t_lockout();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule